// File: doc/BRIEF.md
# Key Event Queue with Offset Peek

This block buffers keypad events between a matrix scanner and a register front end. The scanner offers one event per cycle on a valid/ready push port. Each event is a 7-bit key code and a press/release flag, packed into one byte. The events sit in a 16-slot circular store, described by a start pointer and a fill count. The front end has two ways to read:

- A consuming read moves the start pointer forward first and then returns the slot it now points at. It therefore treats the queue as empty while a single entry remains.
- A peek read returns the slot at a chosen offset from the start pointer and leaves both pointers unchanged.

Push port back-pressure: `push_ready` is held high and the scanner is never stalled. An event that finds the store full is discarded and raises an overflow error instead. While both the error interrupt flag and the overflow error flag are set, every offered event is accepted and silently dropped, and the drop has no other effect.

Consuming read port: `pop_valid` is high when the fill count is at least 2. A read happens in a cycle where both `pop_valid` and `pop_ready` are high, and `pop_data` carries the returned byte in that same cycle. A configuration clear resets both pointers.

Top module: `key_event_fifo`

## Requirements
- R1: A stored event byte has the key code in bits 6:0 and the press flag in bit 7. It is written at slot (start + count) mod 16.
- R2: An accepted push increments the count and sets `irq_keypad` on the next edge.
- R3: A push that finds the count at 16, after any consuming read in the same cycle, is discarded. It sets `irq_error` and `err_fifo_ovr`, and the count and the stored bytes stay unchanged.
- R4: While `irq_error` and `err_fifo_ovr` are both high, a push is dropped: it changes no stored byte, no pointer and no flag.
- R5: With a count of 0 or 1, `pop_valid` is low, `pop_data` is 0x00, and `pop_ready` changes nothing.
- R6: With a count of 2 or more, `pop_data` is the byte at slot (start + 1) mod 16. With `pop_ready` high, the start pointer advances by one and the count drops by one.
- R7: `peek_data` is 0x00 when `peek_offset` is greater than or equal to the count. Otherwise it is the byte at slot (start + offset) mod 16. A peek never changes any state.
- R8: `cfg_clear` zeroes the start pointer and the count on the next edge. It takes priority over a push and over a consuming read in the same cycle.
- R9: When a consuming read and a push fall in the same cycle, the read is applied first, so a push onto a full store that is also being read is accepted.
- R10: `status_ack` clears `irq_keypad` and `irq_error`, and `error_ack` clears `err_fifo_ovr`. In both cases a set in the same cycle wins. `irq` is the OR of the two interrupt flags.
- R11: After reset the count, the start pointer and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Scanner offers an event |
| push_ready | output | 1 | Always high; the scanner is never stalled |
| push_code | input | 7 | Key code of the offered event |
| push_press | input | 1 | 1 for press, 0 for release |
| pop_ready | input | 1 | Front end requests a consuming read |
| pop_valid | output | 1 | Count is at least 2 |
| pop_data | output | 8 | Byte returned by the consuming read |
| peek_offset | input | 5 | Offset from the start pointer for a peek |
| peek_data | output | 8 | Byte at the peek offset, or 0x00 |
| cfg_clear | input | 1 | Zero the start pointer and the count |
| status_ack | input | 1 | Clear both interrupt flags |
| error_ack | input | 1 | Clear the overflow error flag |
| irq_keypad | output | 1 | An event has been queued |
| irq_error | output | 1 | An overflow has occurred |
| err_fifo_ovr | output | 1 | Overflow error flag |
| irq | output | 1 | OR of the interrupt flags |

## Verification
The assertions assume that every control input is a known 0 or 1 in each cycle after reset. They also assume that the acknowledge inputs stay low in the cycle where a flag is expected to hold. The bench drives every input at the falling edge, so each is stable across the rising edge. It raises an acknowledge only on purpose, in steps where a reference model follows the same set-wins rule. The peek offset ranges over 0 to 16, which includes the value one past a full store.

// File: rtl/kef_pkg.sv
package kef_pkg;
  localparam int CODE_W = 7;
  typedef struct packed {
    logic              press;
    logic [CODE_W-1:0] code;
  } key_event_t;
  localparam int EVT_W = $bits(key_event_t);
endpackage

// File: rtl/kef_store.sv
module kef_store
  import kef_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  key_event_t    wr_evt,
  input  logic [AW-1:0] rd_a_idx,
  output key_event_t    rd_a_evt,
  input  logic [AW-1:0] rd_b_idx,
  output key_event_t    rd_b_evt
);
  key_event_t slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slots[g] <= '0;
      else if (wr_en && wr_idx == AW'(g))          slots[g] <= wr_evt;
    end
  end

  assign rd_a_evt = slots[rd_a_idx];
  assign rd_b_evt = slots[rd_b_idx];
endmodule

// File: rtl/kef_ptrs.sv
module kef_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pop_req,
  input  logic          push_req,
  output logic [AW-1:0] start,
  output logic [LW-1:0] count,
  output logic          pop_ok,
  output logic          push_ok,
  output logic          ovf,
  output logic [AW-1:0] wr_idx
);
  logic [LW-1:0] count_after_pop;

  always_comb begin
    pop_ok          = pop_req && !clr && (count > LW'(1));
    count_after_pop = pop_ok ? count - LW'(1) : count;
    push_ok         = push_req && !clr && (count_after_pop != LW'(DEPTH));
    ovf             = push_req && !clr && (count_after_pop == LW'(DEPTH));
    // start+1 and count-1 cancel, so the tail slot is the same either way
    wr_idx          = start + count[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start <= '0;
      count <= '0;
    end else if (clr) begin
      start <= '0;
      count <= '0;
    end else begin
      start <= start + AW'(pop_ok);
      count <= count_after_pop + LW'(push_ok);
    end
  end

  // R8: clear empties the store
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && start == '0));
  // R5: a read at count 0/1 with no push leaves the count alone
  a_r5_short_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !clr && !push_req && count <= LW'(1)) |=> $stable(count));
  // R6: a consuming read alone lowers the count by one and moves start
  a_r6_read_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok) |=> (count == $past(count) - LW'(1)) && (start == $past(start) + AW'(1)));
  // R9: read and push together keep the count
  a_r9_read_then_push: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && push_ok) |=> $stable(count));
  // R3: count never exceeds the store size
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LW'(DEPTH));
endmodule

// File: rtl/kef_flags.sv
module kef_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic push_ok,
  input  logic ovf,
  input  logic status_ack,
  input  logic error_ack,
  output logic irq_keypad,
  output logic irq_error,
  output logic err_fifo_ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_keypad   <= 1'b0;
      irq_error    <= 1'b0;
      err_fifo_ovr <= 1'b0;
    end else begin
      if (push_ok)         irq_keypad <= 1'b1;
      else if (status_ack) irq_keypad <= 1'b0;
      if (ovf)             irq_error <= 1'b1;
      else if (status_ack) irq_error <= 1'b0;
      if (ovf)             err_fifo_ovr <= 1'b1;
      else if (error_ack)  err_fifo_ovr <= 1'b0;
    end
  end

  // R2: an accepted push raises the keypad interrupt
  a_r2_push_irq: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> irq_keypad);
  // R3: an overflow raises both error flags
  a_r3_ovf_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (irq_error && err_fifo_ovr));
  // R10: acknowledge clears unless a set coincides
  a_r10_status_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (status_ack && !push_ok && !ovf) |=> (!irq_keypad && !irq_error));
endmodule

// File: rtl/key_event_fifo.sv
module key_event_fifo
  import kef_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [CODE_W-1:0] push_code,
  input  logic              push_press,
  input  logic              pop_ready,
  output logic              pop_valid,
  output logic [EVT_W-1:0]  pop_data,
  input  logic [LW-1:0]     peek_offset,
  output logic [EVT_W-1:0]  peek_data,
  input  logic              cfg_clear,
  input  logic              status_ack,
  input  logic              error_ack,
  output logic              irq_keypad,
  output logic              irq_error,
  output logic              err_fifo_ovr,
  output logic              irq
);
  logic [AW-1:0] start, wr_idx;
  logic [LW-1:0] count;
  logic          pop_ok, push_ok, ovf, drop, push_req;
  key_event_t    head_evt, peek_evt, new_evt;

  assign push_ready = 1'b1;
  assign drop       = irq_error && err_fifo_ovr;
  assign push_req   = push_valid && !drop;
  assign new_evt    = '{press: push_press, code: push_code};

  kef_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clr(cfg_clear), .pop_req(pop_ready),
    .push_req(push_req), .start(start), .count(count), .pop_ok(pop_ok),
    .push_ok(push_ok), .ovf(ovf), .wr_idx(wr_idx)
  );

  kef_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_idx(wr_idx), .wr_evt(new_evt),
    .rd_a_idx(start + AW'(1)), .rd_a_evt(head_evt),
    .rd_b_idx(start + peek_offset[AW-1:0]), .rd_b_evt(peek_evt)
  );

  kef_flags u_flags (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .ovf(ovf),
    .status_ack(status_ack), .error_ack(error_ack), .irq_keypad(irq_keypad),
    .irq_error(irq_error), .err_fifo_ovr(err_fifo_ovr)
  );

  assign pop_valid = count > LW'(1);
  assign pop_data  = pop_valid ? head_evt : '0;
  assign peek_data = (peek_offset < count) ? peek_evt : '0;
  assign irq       = irq_keypad || irq_error;

  // R4: while dropping, an offered event leaves the error flags in place
  a_r4_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !status_ack && !error_ack) |=> (irq_error && err_fifo_ovr));
  // R4: a dropped event never reaches the store
  a_r4_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && push_valid && !pop_ready && !cfg_clear) |=> $stable(count));
  // R5: no data is offered while the count is below two
  a_r5_zero_when_short: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_valid |-> pop_data == '0);
endmodule

// File: tb/tb_key_event_fifo.sv
`timescale 1ns/1ps
module tb_key_event_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 0, push_press = 0, pop_ready = 0;
  logic       cfg_clear = 0, status_ack = 0, error_ack = 0;
  logic [6:0] push_code = 0;
  logic [4:0] peek_offset = 0;
  logic       push_ready, pop_valid, irq_keypad, irq_error, err_fifo_ovr, irq;
  logic [7:0] pop_data, peek_data;

  int checks = 0, failures = 0;
  logic [7:0] mq [16];
  int ms = 0, ml = 0;
  bit mk = 0, me = 0, mo = 0;

  always #2.5 clk = ~clk;

  key_event_fifo dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_code(push_code), .push_press(push_press), .pop_ready(pop_ready),
    .pop_valid(pop_valid), .pop_data(pop_data), .peek_offset(peek_offset),
    .peek_data(peek_data), .cfg_clear(cfg_clear), .status_ack(status_ack),
    .error_ack(error_ack), .irq_keypad(irq_keypad), .irq_error(irq_error),
    .err_fifo_ovr(err_fifo_ovr), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {push, press, code[6:0], pop, offset[4:0]}
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 1'b1, 7'h3c, 1'b0, 5'd0},
    {1'b0, 1'b0, 7'h00, 1'b1, 5'd0},
    {1'b1, 1'b0, 7'h3c, 1'b0, 5'd1},
    {1'b1, 1'b1, 7'h12, 1'b0, 5'd1},
    {1'b0, 1'b0, 7'h00, 1'b0, 5'd2},
    {1'b0, 1'b0, 7'h00, 1'b0, 5'd3},
    {1'b0, 1'b0, 7'h00, 1'b1, 5'd0},
    {1'b1, 1'b0, 7'h7f, 1'b1, 5'd1},
    {1'b0, 1'b0, 7'h00, 1'b1, 5'd0},
    {1'b0, 1'b0, 7'h00, 1'b1, 5'd1},
    {1'b1, 1'b1, 7'h01, 1'b0, 5'd0},
    {1'b0, 1'b0, 7'h00, 1'b0, 5'd1},
    {1'b0, 1'b0, 7'h00, 1'b1, 5'd2},
    {1'b0, 1'b0, 7'h00, 1'b0, 5'd16}
  };

  task automatic step(bit pv, bit pr, bit [6:0] code, bit pop, bit [4:0] k,
                      bit clr, bit sack, bit eack);
    bit drop, pushok, ovf;
    logic [7:0] e_pop, e_peek;
    @(negedge clk);
    push_valid = pv; push_press = pr; push_code = code; pop_ready = pop;
    peek_offset = k; cfg_clear = clr; status_ack = sack; error_ack = eack;
    #1;
    e_pop  = (ml > 1) ? mq[(ms + 1) % 16] : 8'h00;
    e_peek = (int'(k) < ml) ? mq[(ms + int'(k)) % 16] : 8'h00;
    chk((ml > 1) ? "R6 pop_data" : "R5 pop_data", pop_data, e_pop);
    chk((ml > 1) ? "R6 pop_valid" : "R5 pop_valid", {7'd0, pop_valid}, {7'd0, ml > 1});
    chk("R7 peek_data", peek_data, e_peek);
    chk("R1 push_ready", {7'd0, push_ready}, 8'd1);
    drop = me && mo; pushok = 0; ovf = 0;
    if (clr) begin
      ms = 0; ml = 0;
    end else begin
      if (pop && ml > 1) begin ms = (ms + 1) % 16; ml--; end
      if (pv && !drop) begin
        if (ml == 16) ovf = 1;
        else begin mq[(ms + ml) % 16] = {pr, code}; ml++; pushok = 1; end
      end
    end
    mk = pushok ? 1'b1 : (sack ? 1'b0 : mk);
    me = ovf ? 1'b1 : (sack ? 1'b0 : me);
    mo = ovf ? 1'b1 : (eack ? 1'b0 : mo);
    @(posedge clk); #1;
    chk("R2 irq_keypad", {7'd0, irq_keypad}, {7'd0, mk});
    chk("R3 irq_error", {7'd0, irq_error}, {7'd0, me});
    chk("R10 err_fifo_ovr", {7'd0, err_fifo_ovr}, {7'd0, mo});
    chk("R10 irq", {7'd0, irq}, {7'd0, mk | me});
  endtask

  task automatic peek_chk(string tag, bit [4:0] k, logic [7:0] exp);
    @(negedge clk);
    push_valid = 0; pop_ready = 0; cfg_clear = 0; status_ack = 0; error_ack = 0;
    peek_offset = k; #1;
    chk(tag, peek_data, exp);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mq[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 pop_valid", {7'd0, pop_valid}, 8'd0);
    chk("R11 irq", {6'd0, irq_keypad, irq}, 8'd0);
    chk("R11 errors", {6'd0, irq_error, err_fifo_ovr}, 8'd0);
    chk("R11 peek", peek_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      step(VEC[i][14], VEC[i][13], VEC[i][12:6], VEC[i][5], VEC[i][4:0], 0, 0, 0);
    peek_chk("R1 byte format", 5'd0, {1'b1, 7'h01});

    // R8: clear wins over a push and a read in the same cycle
    step(1, 1, 7'h22, 1, 0, 1, 0, 0);
    peek_chk("R8 emptied", 5'd0, 8'h00);

    // R3: fill all slots, then one more
    for (int i = 0; i < 16; i++) step(1, i[0], 7'(i + 8'h40), 0, 5'(i), 0, 0, 0);
    step(1, 1, 7'h55, 0, 5'd16, 0, 0, 0);
    peek_chk("R3 last kept", 5'd15, {1'b1, 7'h4f});
    peek_chk("R3 beyond", 5'd16, 8'h00);

    // R4: both error flags up, a read frees a slot, the push is still dropped
    step(1, 0, 7'h66, 1, 5'd0, 0, 0, 0);
    peek_chk("R4 no store", 5'd15, 8'h00);
    step(1, 0, 7'h67, 0, 5'd15, 0, 0, 1);

    // R10: overflow flag cleared, error irq still set; push now accepted
    step(1, 1, 7'h68, 0, 5'd15, 0, 1, 0);
    // R9: full store, read and push together
    step(1, 0, 7'h69, 1, 5'd15, 0, 0, 0);
    peek_chk("R9 tail", 5'd15, {1'b0, 7'h69});
    // R10: set and acknowledge together, set wins
    step(1, 1, 7'h6a, 1, 5'd0, 0, 1, 1);

    // R5: drain to one entry, then reads do nothing
    step(0, 0, 0, 0, 0, 1, 1, 1);
    step(1, 0, 7'h11, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    peek_chk("R5 still one", 5'd0, {1'b0, 7'h11});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule